// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a small system control register file. It sits behind a word-addressed access port that takes one write or one read strobe per clock. A key register at word 0 holds the lock state. Writing the correct 32-bit key opens the block, and writing any other value closes it again. While the block is locked, a write to any other register is still carried out, but it is reported on a one-cycle error pulse, so that software mistakes are visible without breaking older code that skips the unlock step.

The block holds a parameterised number of reset-control words. Each word has two addresses. A write to the first address sets the bits that are 1 in the data. A write to the second address clears them. A read from either address returns the same word.

The hardware strap words also have a set address and a clear address, plus a third word, the guard, located two words above the strap's set address. While a strap's guard word is nonzero, writes to that strap's set address and clear address are both dropped. The reset values of the straps come in as parameters.

Accesses to word indices at or beyond the implemented range are reported on the same error pulse. Such a write changes nothing, and such a read returns zero.

Top module: `scu_keyreg_top`

## Requirements
- R1: After reset, every reset-control word and every guard word reads 0. Strap k reads bits [32k+31:32k] of parameter STRAP_INIT. The key register reads 0 (locked). The err output is 0.
- R2: A write to word 0 with data 32'h1688_A8A8 opens the block, and a read of word 0 then returns 1. A write of any other value returns it to locked, and a read then returns 0.
- R3: While the block is locked, a write to any in-range word other than word 0 raises err for exactly the cycle after the strobe. The write is still applied.
- R4: A write to a word index of NUM_WORDS (default 384) or above changes no register and raises err in the cycle after the strobe. A read there returns rdata = 0 and raises err.
- R5: Reset-control word i has its set address at word 16+4i (i = 0 or 1). A write there leaves the word equal to the old value ORed with the data.
- R6: The clear address of reset-control word i is at word 17+4i. A write there leaves the word equal to the old value ANDed with the inverted data. A read of the clear address returns the word's value.
- R7: Strap k has its set address at word 320+4k (k = 0 or 1). While its guard word is 0, a write there ORs the data into the strap.
- R8: The clear address of strap k is at word 321+4k. While its guard word is 0, a write there clears the bits that are 1 in the data. A read of the clear address returns the strap value.
- R9: While the guard word of strap k (word 322+4k) is nonzero, writes to that strap's set address and clear address leave the strap unchanged.
- R10: A guard word is a plain read/write register. A read returns the last value written to it.
- R11: An in-range word index with no register behind it reads 0, and a write there changes no register.
- R12: Read data appears on rdata in the cycle after the read strobe. rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W (10) | Word index of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle error pulse: out-of-range access or write while locked |

## Verification
The assertions assume that the read strobe and the write strobe are never high in the same cycle, and one property checks exactly that. The properties on the guarded set/clear paths also assume that the data and the strobe are stable across the sampling edge. The bench issues exactly one operation per access, driving the inputs on the falling edge and releasing the strobe on the next falling edge. Its random addresses come mostly from the implemented words, with some unimplemented in-range words and some out-of-range words. Key writes use the correct key half of the time, and guard writes use zero half of the time, so that the locked and unlocked states and the frozen and open strap states all occur.

// File: rtl/scu_pkg.sv
// Package: shared constants for the key-protected control register file.
// Assumes word indexing; all map positions derive from these bases.
package scu_pkg;
    localparam int          DW            = 32;
    localparam logic [31:0] UNLOCK_KEY    = 32'h1688_A8A8;
    localparam int          KEY_IDX       = 0;
    localparam int          RST_BASE      = 16;
    localparam int          RST_STRIDE    = 4;
    localparam int          STRAP_BASE    = 320;
    localparam int          STRAP_STRIDE  = 4;
    localparam int          GUARD_OFFSET  = 2;
endpackage

// File: rtl/scu_addr_dec.sv
// Module: scu_addr_dec
// Decodes a word index into one-hot register hits plus an in-range flag.
// Assumes every mapped index lies below NUM_WORDS and fits in ADDR_W bits.
module scu_addr_dec
    import scu_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_WORDS = 384,
    parameter int NUM_RST   = 2,
    parameter int NUM_STRAP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 strobe,
    output logic                 in_range,
    output logic                 hit_key,
    output logic [NUM_RST-1:0]   hit_rst_set,
    output logic [NUM_RST-1:0]   hit_rst_clr,
    output logic [NUM_STRAP-1:0] hit_strap_set,
    output logic [NUM_STRAP-1:0] hit_strap_clr,
    output logic [NUM_STRAP-1:0] hit_guard
);
    localparam int PAD_W = 32 - ADDR_W;

    // Range check against the implemented word count.
    assign in_range = ({{PAD_W{1'b0}}, addr} < 32'(NUM_WORDS));
    // Key register hit.
    assign hit_key  = (addr == ADDR_W'(KEY_IDX));

    genvar i;
    generate
        for (i = 0; i < NUM_RST; i++) begin : g_rst
            // Set and clear aliases of one reset-control word.
            assign hit_rst_set[i] = (addr == ADDR_W'(RST_BASE + RST_STRIDE*i));
            assign hit_rst_clr[i] = (addr == ADDR_W'(RST_BASE + RST_STRIDE*i + 1));
        end
        for (i = 0; i < NUM_STRAP; i++) begin : g_strap
            // Set, clear and guard addresses of one strap.
            assign hit_strap_set[i] = (addr == ADDR_W'(STRAP_BASE + STRAP_STRIDE*i));
            assign hit_strap_clr[i] = (addr == ADDR_W'(STRAP_BASE + STRAP_STRIDE*i + 1));
            assign hit_guard[i]     = (addr == ADDR_W'(STRAP_BASE + STRAP_STRIDE*i + GUARD_OFFSET));
        end
    endgenerate

    AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $onehot0({hit_key, hit_rst_set, hit_rst_clr, hit_strap_set, hit_strap_clr, hit_guard})); // R11
    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (hit_key || (|hit_rst_set) || (|hit_strap_set) || (|hit_guard))) |-> in_range); // R4
endmodule

// File: rtl/scu_setclr_reg.sv
// Module: scu_setclr_reg
// One word with a write-1-to-set path and a write-1-to-clear path.
// Both paths are frozen while `freeze` is high; tie it low when unused.
module scu_setclr_reg
    import scu_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          set_hit,
    input  logic          clr_hit,
    input  logic          freeze,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    // Applies set or clear writes unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (wr_en && !freeze) begin
            if (set_hit)      q <= q | wdata;
            else if (clr_hit) q <= q & ~wdata;
        end
    end

    AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_hit && !freeze) |=> ((q & $past(wdata)) == $past(wdata))); // R5
    AST_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_hit && !freeze) |=> ((q & $past(wdata)) == '0)); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && freeze) |=> $stable(q)); // R9
endmodule

// File: rtl/scu_keyreg_top.sv
// Module: scu_keyreg_top
// Key-protected control register file: key lock, reset-control set/clear
// words, guarded strap words, registered readback and a one-cycle error pulse.
// Assumes at most one of wr_en / rd_en per cycle.
module scu_keyreg_top
    import scu_pkg::*;
#(
    parameter int                        ADDR_W     = 10,
    parameter int                        NUM_WORDS  = 384,
    parameter int                        NUM_RST    = 2,
    parameter int                        NUM_STRAP  = 2,
    parameter logic [NUM_STRAP*32-1:0]   STRAP_INIT = {32'h0000_00F0, 32'h1234_5601}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              err
);
    logic                 in_range, hit_key;
    logic [NUM_RST-1:0]   hit_rst_set, hit_rst_clr;
    logic [NUM_STRAP-1:0] hit_strap_set, hit_strap_clr, hit_guard;
    logic                 unlocked_q;
    logic                 wr_ok;
    logic [DW-1:0]        rst_q   [NUM_RST];
    logic [DW-1:0]        strap_q [NUM_STRAP];
    logic [DW-1:0]        guard_q [NUM_STRAP];
    logic [DW-1:0]        rd_val;

    scu_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
        .NUM_RST(NUM_RST), .NUM_STRAP(NUM_STRAP)
    ) i_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(wr_en | rd_en),
        .in_range(in_range), .hit_key(hit_key),
        .hit_rst_set(hit_rst_set), .hit_rst_clr(hit_rst_clr),
        .hit_strap_set(hit_strap_set), .hit_strap_clr(hit_strap_clr),
        .hit_guard(hit_guard)
    );

    assign wr_ok = wr_en && in_range;

    // Lock state follows the most recent key write.
    always_ff @(posedge clk) begin
        if (!rst_n)                unlocked_q <= 1'b0;
        else if (wr_ok && hit_key) unlocked_q <= (wdata == UNLOCK_KEY);
    end

    genvar i;
    generate
        for (i = 0; i < NUM_RST; i++) begin : g_rst
            scu_setclr_reg #(.INIT(32'h0)) i_rst (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_ok),
                .set_hit(hit_rst_set[i]), .clr_hit(hit_rst_clr[i]),
                .freeze(1'b0), .wdata(wdata), .q(rst_q[i])
            );
        end
        for (i = 0; i < NUM_STRAP; i++) begin : g_strap
            scu_setclr_reg #(.INIT(STRAP_INIT[i*32 +: 32])) i_strap (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_ok),
                .set_hit(hit_strap_set[i]), .clr_hit(hit_strap_clr[i]),
                .freeze(guard_q[i] != '0), .wdata(wdata), .q(strap_q[i])
            );
            // Plain read/write guard word for this strap.
            always_ff @(posedge clk) begin
                if (!rst_n)                     guard_q[i] <= '0;
                else if (wr_ok && hit_guard[i]) guard_q[i] <= wdata;
            end
        end
    endgenerate

    // Readback mux; clear aliases return their base word.
    always_comb begin
        rd_val = '0;
        if (hit_key) rd_val = {{(DW-1){1'b0}}, unlocked_q};
        for (int k = 0; k < NUM_RST; k++)
            if (hit_rst_set[k] || hit_rst_clr[k]) rd_val = rst_q[k];
        for (int k = 0; k < NUM_STRAP; k++) begin
            if (hit_strap_set[k] || hit_strap_clr[k]) rd_val = strap_q[k];
            if (hit_guard[k])                         rd_val = guard_q[k];
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= in_range ? rd_val : '0;
    end

    // Error pulse for out-of-range accesses and locked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= ((wr_en || rd_en) && !in_range) ||
                           (wr_ok && !hit_key && !unlocked_q);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)); // R12
    AST_KEY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata == UNLOCK_KEY) |=> unlocked_q); // R2
    AST_KEY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata != UNLOCK_KEY) |=> !unlocked_q); // R2
    AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && addr != '0 && !unlocked_q) |=> err); // R3
    AST_OOB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !in_range) |=> err); // R4
    AST_OOB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> (rdata == '0)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata)); // R12
endmodule

// File: tb/test_scu_keyreg_top.sv
`timescale 1ns/1ps
module test_scu_keyreg_top;
    localparam int          AW    = 10;
    localparam int          NW    = 384;
    localparam logic [31:0] KEY   = 32'h1688_A8A8;
    localparam logic [31:0] S0    = 32'h1234_5601;
    localparam logic [31:0] S1    = 32'h0000_00F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;

    int total = 0, bad = 0;
    logic        m_unl;
    logic [31:0] m_rst [2];
    logic [31:0] m_strap [2];
    logic [31:0] m_guard [2];

    always #2.5 clk = ~clk;

    scu_keyreg_top i_scu_keyreg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    function automatic string tag_of(int a);
        if (a == 0) return "R2";
        if (a >= NW) return "R4";
        for (int i = 0; i < 2; i++) begin
            if (a == 16+4*i) return "R5";
            if (a == 17+4*i) return "R6";
            if (a == 320+4*i) return "R7";
            if (a == 321+4*i) return "R8";
            if (a == 322+4*i) return "R10";
        end
        return "R11";
    endfunction

    function automatic logic [31:0] m_read(int a);
        if (a >= NW) return 32'h0;
        if (a == 0) return {31'b0, m_unl};
        for (int i = 0; i < 2; i++) begin
            if (a == 16+4*i || a == 17+4*i) return m_rst[i];
            if (a == 320+4*i || a == 321+4*i) return m_strap[i];
            if (a == 322+4*i) return m_guard[i];
        end
        return 32'h0;
    endfunction

    function automatic void m_write(int a, logic [31:0] d);
        if (a >= NW) return;
        if (a == 0) m_unl = (d == KEY);
        for (int i = 0; i < 2; i++) begin
            if (a == 16+4*i) m_rst[i] = m_rst[i] | d;
            if (a == 17+4*i) m_rst[i] = m_rst[i] & ~d;
            if (a == 320+4*i && m_guard[i] == 0) m_strap[i] = m_strap[i] | d;
            if (a == 321+4*i && m_guard[i] == 0) m_strap[i] = m_strap[i] & ~d;
            if (a == 322+4*i) m_guard[i] = d;
        end
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        logic e;
        e = (a >= NW) || (a != 0 && !m_unl);
        m_write(a, d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " err"}, {31'b0, err}, {31'b0, e});
    endtask

    task automatic rd(int a, string tag);
        logic [31:0] x;
        x = m_read(a);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, x);
        chk({tag, " err"}, {31'b0, err}, {31'b0, (a >= NW)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_unl = 1'b0;
        m_rst = '{default: 32'h0};
        m_guard = '{default: 32'h0};
        m_strap[0] = S0; m_strap[1] = S1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 err", {31'b0, err}, 32'h0);
        foreach (m_rst[i]) rd(16+4*i, "R1");
        foreach (m_strap[i]) rd(320+4*i, "R1");
        foreach (m_guard[i]) rd(322+4*i, "R1");
        rd(0, "R1");
        // Locked write: flagged but applied
        wr(16, 32'h0000_00A5, "R3");
        rd(16, "R3");
        // Wrong key stays locked, right key opens, wrong key closes
        wr(0, 32'hDEAD_BEEF, "R2"); rd(0, "R2");
        wr(0, KEY, "R2");           rd(0, "R2");
        wr(20, 32'hF0F0_0000, "R5"); rd(20, "R5");
        wr(21, 32'h3000_0000, "R6"); rd(21, "R6"); rd(20, "R6");
        wr(321, 32'h0000_0001, "R8"); rd(320, "R8");
        wr(324, 32'h0F00_0000, "R7"); rd(325, "R7");
        // Guard freezes both paths
        wr(322, 32'h1, "R10"); rd(322, "R10");
        wr(320, 32'hFFFF_FFFF, "R9"); rd(320, "R9");
        wr(321, 32'hFFFF_FFFF, "R9"); rd(320, "R9");
        wr(322, 32'h0, "R10");
        wr(321, 32'h0000_0200, "R8"); rd(320, "R8");
        // Out of range and unimplemented words
        wr(NW, 32'hFFFF_FFFF, "R4"); rd(NW, "R4"); rd(1023, "R4");
        wr(5, 32'h1234_5678, "R11"); rd(5, "R11");
        rd(16, "R12"); @(negedge clk); chk("R12 hold", rdata, m_read(16));
        wr(0, 32'h0, "R2"); rd(0, "R2");
        wr(17, 32'hFFFF_FFFF, "R3"); rd(16, "R3");
        // Random mix
        for (int n = 0; n < 800; n++) begin
            int a;
            int sel;
            logic [31:0] d;
            sel = $urandom_range(0, 15);
            case (sel)
                0: a = 0;
                1: a = 16;  2: a = 17;  3: a = 20;  4: a = 21;
                5: a = 320; 6: a = 321; 7: a = 322;
                8: a = 324; 9: a = 325; 10: a = 326;
                11: a = $urandom_range(NW, 1023);
                12: a = $urandom_range(1, 15);
                default: a = (sel == 13) ? 0 : 16 + 4 * $urandom_range(0, 1);
            endcase
            d = $urandom;
            if (a == 0 && $urandom_range(0, 1) == 1) d = KEY;
            if ((a == 322 || a == 326) && $urandom_range(0, 1) == 1) d = 32'h0;
            if ($urandom_range(0, 1) == 1) wr(a, d, tag_of(a));
            else rd(a, tag_of(a));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule